// File: doc/BRIEF.md
# Capacitive Storage Node with Decay

This block is a clocked, cycle-level model of a net that stores charge. On every rising clock edge it takes one already-resolved driver, given as a value and a strength, and decides what the node holds next. A driver that is stronger than the node's charge takes the node over, exactly as an ordinary wire would. When the driver lets go, the node does not float. It keeps its last value at a capacitive strength that follows from its configured size.

While the node is in that held state, a decay timer counts clock edges. After a programmable number of edges the stored value turns unknown. A second input port carries the value and size of a neighbouring node that a pass device may connect to this one. When that connection is enabled, the two charges are compared and the larger capacitance decides the result.

The node samples its inputs on every edge and always presents a state. There is no data stream here, so no valid/ready handshake applies: every pin is a plain level, and a new input pattern takes effect at the next edge.

Top module: `capnode`

## Requirements
- R1: While `rst_n` is low, the node outputs value x (code 2'b10), holds the flag `node_held`=1, and outputs as strength the capacitive strength of `cap_size`.
- R2: Value codes are 2'b00=0, 2'b01=1, 2'b10=x and 2'b11=z. A z driver value, or a driver strength of 0, means the driver is released. Sizes map to capacitive strengths as 2'b01 small=1, 2'b10 medium=2, 2'b11 large=3, and 2'b00 selects medium.
- R3: The reference strength is `node_str` while the node is held, and otherwise the strength of `cap_size`. An active driver whose strength exceeds the reference sets the node to its value and strength at the next edge, with `node_held`=0.
- R4: When a driven node is released, at the next edge it keeps its value, takes the strength of `cap_size`, and sets `node_held`=1. The node output is never z.
- R5: An active driver whose strength equals the reference gives x at that strength when its value differs from the held value. When the values match, the node does not change.
- R6: An active driver weaker than the reference has no effect on the held value or strength.
- R7: With `decay_lim`=N, where N is nonzero, the node keeps its value for N consecutive held edges and turns x at edge N+1. With `decay_lim`=0 the value is held without limit.
- R8: The decay count restarts from zero on every edge at which a driver wins the node. Edges where the driver does not win do not restart it.
- R9: On a held edge with `share_en`=1 and a peer value other than z, the larger strength wins and the node takes the peer's value at the peer's strength. Equal strengths with different values give x. A smaller peer has no effect.
- R10: Peer input is ignored when a driver wins the node, or when the peer value is z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_val | input | 2 | Resolved driver value code |
| drv_str | input | 3 | Resolved driver strength, 0 to 7 |
| cap_size | input | 2 | Capacitance size of this node |
| decay_lim | input | 16 | Held edges before the value turns x; 0 disables decay |
| share_en | input | 1 | Pass device to the peer node is conducting |
| peer_val | input | 2 | Value code held by the peer node |
| peer_size | input | 2 | Capacitance size of the peer node |
| node_val | output | 2 | Node value code |
| node_str | output | 3 | Node strength |
| node_held | output | 1 | 1 when the node holds charge, 0 when a driver owns it |

## Verification
The hold properties assume that no peer sharing and no decay are active. They also assume that a released driver or a driver weaker than the held strength is the only input, so they say nothing about cycles with `share_en` high or a nonzero `decay_lim`. Directed phases keep `share_en` low and `decay_lim` at zero except where they exercise sharing or decay, and they drive each size code, including the default code. A long random phase then mixes every value code, strength, size, decay limit and peer setting, and a behavioural model checks the node on every clock edge.

// File: rtl/capnode_pkg.sv
package capnode_pkg;
  localparam logic [1:0] LV_0 = 2'b00;
  localparam logic [1:0] LV_1 = 2'b01;
  localparam logic [1:0] LV_X = 2'b10;
  localparam logic [1:0] LV_Z = 2'b11;

  localparam int STR_W = 3;

  // capacitive strength for a size code; code 0 falls back to medium
  function automatic logic [STR_W-1:0] size_to_str(input logic [1:0] sz);
    logic [STR_W-1:0] s;
    case (sz)
      2'b01:   s = 3'd1;
      2'b10:   s = 3'd2;
      2'b11:   s = 3'd3;
      default: s = 3'd2;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/capnode_contend.sv
module capnode_contend
  import capnode_pkg::*;
(
  input  logic             held_q,
  input  logic [1:0]       val_q,
  input  logic [STR_W-1:0] str_q,
  input  logic [1:0]       drv_val,
  input  logic [STR_W-1:0] drv_str,
  input  logic [STR_W-1:0] own_str,
  output logic             win,
  output logic [1:0]       c_val,
  output logic [STR_W-1:0] c_str
);
  logic [STR_W-1:0] ref_str;
  logic             drv_on;

  assign ref_str = held_q ? str_q : own_str;
  assign drv_on  = (drv_val != LV_Z) && (drv_str != '0);

  always_comb begin
    win   = 1'b0;
    c_val = val_q;
    c_str = ref_str;
    if (drv_on && (drv_str > ref_str)) begin
      win   = 1'b1;
      c_val = drv_val;
      c_str = drv_str;
    end else if (drv_on && (drv_str == ref_str) && (drv_val != val_q)) begin
      c_val = LV_X;
    end
  end
endmodule

// File: rtl/capnode_share.sv
module capnode_share
  import capnode_pkg::*;
(
  input  logic             share_en,
  input  logic [1:0]       peer_val,
  input  logic [1:0]       peer_size,
  input  logic [1:0]       in_val,
  input  logic [STR_W-1:0] in_str,
  output logic [1:0]       s_val,
  output logic [STR_W-1:0] s_str
);
  logic [STR_W-1:0] peer_str;

  assign peer_str = size_to_str(peer_size);

  always_comb begin
    s_val = in_val;
    s_str = in_str;
    if (share_en && (peer_val != LV_Z)) begin
      if (peer_str > in_str) begin
        s_val = peer_val;
        s_str = peer_str;
      end else if ((peer_str == in_str) && (peer_val != in_val)) begin
        s_val = LV_X;
      end
    end
  end
endmodule

// File: rtl/capnode_decay.sv
module capnode_decay #(
  parameter int DCY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DCY_W-1:0] lim,
  output logic             expired
);
  localparam logic [DCY_W-1:0] CNT_TOP = '1;

  logic [DCY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (lim != '0) && (cnt_q >= lim);
endmodule

// File: rtl/capnode.sv
module capnode
  import capnode_pkg::*;
#(
  parameter int DCY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       drv_val,
  input  logic [2:0]       drv_str,
  input  logic [1:0]       cap_size,
  input  logic [DCY_W-1:0] decay_lim,
  input  logic             share_en,
  input  logic [1:0]       peer_val,
  input  logic [1:0]       peer_size,
  output logic [1:0]       node_val,
  output logic [2:0]       node_str,
  output logic             node_held
);
  logic [1:0]       val_q;
  logic [STR_W-1:0] str_q;
  logic             held_q;
  logic [STR_W-1:0] own_str;
  logic             win;
  logic [1:0]       c_val, s_val, n_val;
  logic [STR_W-1:0] c_str, s_str, n_str;
  logic             expired;

  assign own_str = size_to_str(cap_size);

  capnode_contend u_contend (
    .held_q (held_q),
    .val_q  (val_q),
    .str_q  (str_q),
    .drv_val(drv_val),
    .drv_str(drv_str),
    .own_str(own_str),
    .win    (win),
    .c_val  (c_val),
    .c_str  (c_str)
  );

  capnode_share u_share (
    .share_en (share_en),
    .peer_val (peer_val),
    .peer_size(peer_size),
    .in_val   (c_val),
    .in_str   (c_str),
    .s_val    (s_val),
    .s_str    (s_str)
  );

  capnode_decay #(.DCY_W(DCY_W)) u_decay (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (win),
    .lim    (decay_lim),
    .expired(expired)
  );

  always_comb begin
    if (win) begin
      n_val = c_val;
      n_str = c_str;
    end else begin
      n_val = expired ? LV_X : s_val;
      n_str = s_str;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= LV_X;
      str_q  <= own_str;
      held_q <= 1'b1;
    end else begin
      val_q  <= n_val;
      str_q  <= n_str;
      held_q <= !win;
    end
  end

  assign node_val  = val_q;
  assign node_str  = str_q;
  assign node_held = held_q;
endmodule

// File: rtl/capnode_chk.sv
module capnode_chk
  import capnode_pkg::*;
#(
  parameter int DCY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       drv_val,
  input logic [2:0]       drv_str,
  input logic [1:0]       cap_size,
  input logic [DCY_W-1:0] decay_lim,
  input logic             share_en,
  input logic [1:0]       node_val,
  input logic [2:0]       node_str,
  input logic             node_held
);
  logic drv_on;
  assign drv_on = (drv_val != LV_Z) && (drv_str != 3'd0);

  // R3
  strong_drive_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_on && drv_str >= 3'd4) |=>
      (!node_held && node_val == $past(drv_val) && node_str == $past(drv_str)));

  // R4
  release_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_on && !share_en && decay_lim == '0 && !node_held) |=>
      (node_held && node_val == $past(node_val) && node_str == size_to_str($past(cap_size))));

  // R4
  never_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_val != LV_Z);

  // R6
  weak_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_held && drv_on && drv_str < node_str && !share_en && decay_lim == '0) |=>
      ($stable(node_val) && $stable(node_str) && node_held));

  // R7
  hold_forever_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_held && !drv_on && !share_en && decay_lim == '0) |=>
      ($stable(node_val) && $stable(node_str)));

  // R4
  held_strength_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_held |-> (node_str >= 3'd1 && node_str <= 3'd3));
endmodule

bind capnode capnode_chk #(.DCY_W(DCY_W)) u_chk (.*);

// File: tb/capnode_test.sv
`timescale 1ns/1ps
module capnode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  drv_val = 2'b11;
  logic [2:0]  drv_str = 3'd0;
  logic [1:0]  cap_size = 2'b11;
  logic [15:0] decay_lim = 16'd0;
  logic        share_en = 1'b0;
  logic [1:0]  peer_val = 2'b11;
  logic [1:0]  peer_size = 2'b10;
  logic [1:0]  node_val;
  logic [2:0]  node_str;
  logic        node_held;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // behavioural reference
  int m_val, m_str, m_cnt, m_own, m_ref, m_v, m_s, m_ps;
  bit m_held, m_on;

  capnode uut (
    .clk(clk), .rst_n(rst_n), .drv_val(drv_val), .drv_str(drv_str),
    .cap_size(cap_size), .decay_lim(decay_lim), .share_en(share_en),
    .peer_val(peer_val), .peer_size(peer_size),
    .node_val(node_val), .node_str(node_str), .node_held(node_held)
  );

  always #2 clk = ~clk;

  function automatic int cap_of(input int sz);
    if (sz == 1) return 1;
    if (sz == 3) return 3;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_val = 2; m_str = cap_of(cap_size); m_held = 1; m_cnt = 0;
    end else begin
      m_own = cap_of(cap_size);
      m_ref = m_held ? m_str : m_own;
      m_on  = (drv_val != 2'b11) && (drv_str != 0);
      if (m_on && drv_str > m_ref) begin
        m_val = drv_val; m_str = drv_str; m_held = 0; m_cnt = 0;
      end else begin
        m_v = m_val; m_s = m_ref;
        if (m_on && drv_str == m_ref && drv_val != m_val) m_v = 2;
        if (share_en && peer_val != 2'b11) begin
          m_ps = cap_of(peer_size);
          if (m_ps > m_s) begin m_v = peer_val; m_s = m_ps; end
          else if (m_ps == m_s && peer_val != m_v) m_v = 2;
        end
        if (decay_lim != 0 && m_cnt >= decay_lim) m_v = 2;
        m_val = m_v; m_str = m_s; m_held = 1;
        if (m_cnt < 65535) m_cnt++;
      end
    end
  end

  task automatic check(input string t, input int gv, input int gs, input int gh,
                       input int ev, input int es, input int eh);
    total++;
    if (gv != ev || gs != es || gh != eh) begin
      bad++;
      $display("FAIL %s: got val=%0d str=%0d held=%0d expected val=%0d str=%0d held=%0d",
               t, gv, gs, gh, ev, es, eh);
    end
  endtask

  // one clock edge, then compare against the model away from the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(tag, node_val, node_str, node_held, m_val, m_str, m_held);
  endtask

  task automatic drive(input logic [1:0] v, input logic [2:0] s);
    drv_val = v; drv_str = s;
  endtask

  task automatic release_drv();
    drv_val = 2'b11; drv_str = 3'd0;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, large size
    check("R1", node_val, node_str, node_held, 2, 3, 1);
    rst_n = 1'b1;

    // R3 strong driver takes the node
    tag = "R3"; drive(2'b01, 3'd6); tick();
    check("R3", node_val, node_str, node_held, 1, 6, 0);

    // R4 release keeps value at large strength
    tag = "R4"; release_drv(); tick();
    check("R4", node_val, node_str, node_held, 1, 3, 1);
    // R7 no decay configured: holds
    tag = "R7";
    for (int i = 0; i < 40; i++) tick();
    check("R7", node_val, node_str, node_held, 1, 3, 1);

    // R6 weaker opposite driver ignored
    tag = "R6"; drive(2'b00, 3'd2); tick();
    check("R6", node_val, node_str, node_held, 1, 3, 1);

    // R5 equal strength, same value: unchanged
    tag = "R5"; drive(2'b01, 3'd3); tick();
    check("R5", node_val, node_str, node_held, 1, 3, 1);
    // R5 equal strength, opposite value: x
    drive(2'b00, 3'd3); tick();
    check("R5", node_val, node_str, node_held, 2, 3, 1);

    // R3 weak (4) above large (3) wins
    tag = "R3"; drive(2'b00, 3'd4); tick();
    check("R3", node_val, node_str, node_held, 0, 4, 0);

    // R7 decay after 5 held edges
    tag = "R7"; drive(2'b01, 3'd6); tick();
    decay_lim = 16'd5; release_drv();
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R7", node_val, node_str, node_held, 1, 3, 1);
    end
    tick();
    check("R7", node_val, node_str, node_held, 2, 3, 1);

    // R8 restart of the decay count on a winning drive
    tag = "R8"; decay_lim = 16'd4;
    drive(2'b00, 3'd5); tick(); release_drv();
    for (int k = 0; k < 3; k++) tick();
    check("R8", node_val, node_str, node_held, 0, 3, 1);
    drive(2'b00, 3'd5); tick(); release_drv();
    for (int k = 0; k < 4; k++) tick();
    check("R8", node_val, node_str, node_held, 0, 3, 1);
    tick();
    check("R8", node_val, node_str, node_held, 2, 3, 1);
    decay_lim = 16'd0;

    // R2 default size code gives medium
    tag = "R2"; cap_size = 2'b00; drive(2'b01, 3'd7); tick(); release_drv(); tick();
    check("R2", node_val, node_str, node_held, 1, 2, 1);

    // R9 larger peer wins
    tag = "R9"; cap_size = 2'b01; drive(2'b01, 3'd6); tick();
    release_drv(); share_en = 1'b1; peer_val = 2'b00; peer_size = 2'b11; tick();
    check("R9", node_val, node_str, node_held, 0, 3, 1);
    // R9 equal sizes, opposite values
    share_en = 1'b0; cap_size = 2'b10; drive(2'b01, 3'd6); tick();
    release_drv(); share_en = 1'b1; peer_val = 2'b00; peer_size = 2'b10; tick();
    check("R9", node_val, node_str, node_held, 2, 2, 1);
    // R9 smaller peer has no effect
    share_en = 1'b0; cap_size = 2'b11; drive(2'b01, 3'd6); tick();
    release_drv(); share_en = 1'b1; peer_val = 2'b00; peer_size = 2'b01; tick();
    check("R9", node_val, node_str, node_held, 1, 3, 1);

    // R10 winning driver overrides peer
    tag = "R10"; cap_size = 2'b01; peer_size = 2'b11; peer_val = 2'b00;
    drive(2'b01, 3'd6); tick();
    check("R10", node_val, node_str, node_held, 1, 6, 0);
    // R10 z peer ignored
    release_drv(); peer_val = 2'b11; tick();
    check("R10", node_val, node_str, node_held, 1, 1, 1);
    share_en = 1'b0;

    // mixed stimulus, R3 and R9 interplay against the model
    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      drv_val   = 2'($urandom_range(0, 3));
      drv_str   = 3'($urandom_range(0, 7));
      if ((n % 16) == 0) cap_size = 2'($urandom_range(0, 3));
      if ((n % 64) == 0) decay_lim = 16'($urandom_range(0, 6));
      share_en  = 1'($urandom_range(0, 1));
      peer_val  = 2'($urandom_range(0, 3));
      peer_size = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) != 0) release_drv();
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule